// File: doc/BRIEF.md
# RV64I Integer Execute Unit

This block decodes and executes one 64-bit base-integer arithmetic instruction in a single combinational pass. It accepts a 32-bit instruction word and the two 64-bit source register values that a register file has already read out. It returns the computed value, the destination register index, a write strobe and a flag that marks an unsupported encoding. Four instruction groups are covered: register-register, register-register on 32-bit words, register-immediate, and register-immediate on 32-bit words.

Inside, a decoder turns the opcode and function fields into a small bundle of strobes. These strobes select the operation, pick the immediate or the second register as the right-hand operand, and request the 32-bit word form. A datapath computes the selected value from those strobes. The block holds no state. A pipeline places it between operand read and write-back, and a trap unit outside the block acts on the illegal flag.

Top module: `rvx_exec_unit`

## Requirements
- R1: Bits [6:2] of the instruction select the group: 01100 register-register, 01110 register-register word, 00100 register-immediate, 00110 register-immediate word. Any other value is illegal. Bits [1:0] and [19:15] are not examined.
- R2: In the register-register group, (funct3 = bits [14:12], funct7 = bits [31:25]) decodes as follows: (000,0000000) add, (000,0100000) subtract, (001,0000000) shift left, (010,0000000) signed less-than, (011,0000000) unsigned less-than, (100,0000000) xor, (101,0000000) logical right shift, (101,0100000) arithmetic right shift, (110,0000000) or, (111,0000000) and. Every other pair is illegal.
- R3: In the register-register word group, only five encodings are legal: (000,0000000) add, (000,0100000) subtract, (001,0000000) shift left, (101,0000000) logical right shift and (101,0100000) arithmetic right shift.
- R4: In the register-immediate group, funct3 values 000 add, 010 signed less-than, 011 unsigned less-than, 100 xor, 110 or and 111 and are legal for any upper bits. The right operand is bits [31:20] sign-extended to 64 bits.
- R5: Register-immediate shifts check bits [31:26]. Funct3 001 needs 000000 for shift left. Funct3 101 needs 000000 for logical right shift and 010000 for arithmetic right shift. Any other value is illegal.
- R6: In the register-immediate word group, funct3 000 is add. Shifts check bits [31:25]: funct3 001 needs 0000000, and funct3 101 needs 0000000 for logical or 0100000 for arithmetic. Every other funct3 is illegal.
- R7: 64-bit shifts use the low 6 bits of the right operand as the shift amount. Word shifts use the low 5 bits.
- R8: Every word-group result is its low 32 bits sign-extended to 64 bits. The word arithmetic right shift treats the low 32 source bits as a signed value.
- R9: The signed less-than forms compare as signed 64-bit values, and the unsigned forms (including the immediate form, on the sign-extended immediate) compare as unsigned. The result is 1 when the comparison holds and 0 otherwise.
- R10: Add and subtract wrap modulo 2^64.
- R11: When the illegal flag is high, the write strobe is low and the result is zero.
- R12: The destination index is bits [11:7]. The write strobe is low when that index is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rs1Val | input | 64 | First source operand |
| rs2Val | input | 64 | Second source operand (register forms) |
| result | output | 64 | Computed value |
| rdIdx | output | 5 | Destination register index |
| wrEn | output | 1 | Write strobe for the destination |
| illegal | output | 1 | Unsupported encoding flag |

## Verification
The block has no internal state, so a wrong strobe from the decoder shows up at the ports within the same evaluation. A misdecoded operation appears as a wrong result value. A lost word strobe appears as upper bits that are not a copy of bit 31. A wrong legality decision appears as a flipped illegal flag or as a write strobe that stays high on an illegal encoding. Each clock the bench compares all four outputs against a behavioural model, so any such fault is reported in the cycle its encoding is applied. The stimulus covers directed boundary values for shift amounts, sign bits and wrap-around, and biased random encodings for the rest.

// File: rtl/rvx_exec_pkg.sv
package rvx_exec_pkg;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR,  ALU_AND
  } aluOp_e;

  localparam logic [4:0] GRP_REG    = 5'b01100;
  localparam logic [4:0] GRP_REG_W  = 5'b01110;
  localparam logic [4:0] GRP_IMM    = 5'b00100;
  localparam logic [4:0] GRP_IMM_W  = 5'b00110;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;
  localparam logic [5:0] F6_BASE = 6'b000000;
  localparam logic [5:0] F6_ALT  = 6'b010000;

  typedef struct packed {
    aluOp_e aluOp;
    logic   useImm;
    logic   isWord;
    logic   illegal;
  } execCtrl_t;

endpackage

// File: rtl/rvx_exec_ctrl.sv
module rvx_exec_ctrl
  import rvx_exec_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [4:0]       grp,
  input  logic [2:0]       funct3,
  input  logic [6:0]       funct7,
  input  logic [IDX_W-1:0] rdField,
  output execCtrl_t        ctrl,
  output logic             wrEn
);

  logic [5:0] funct6;
  assign funct6 = funct7[6:1];

  always_comb begin
    ctrl.aluOp   = ALU_ADD;
    ctrl.useImm  = 1'b0;
    ctrl.isWord  = 1'b0;
    ctrl.illegal = 1'b1;
    unique case (grp)
      GRP_REG: begin
        if (funct7 == F7_BASE) begin
          ctrl.illegal = 1'b0;
          unique case (funct3)
            3'b000: ctrl.aluOp = ALU_ADD;
            3'b001: ctrl.aluOp = ALU_SLL;
            3'b010: ctrl.aluOp = ALU_SLT;
            3'b011: ctrl.aluOp = ALU_SLTU;
            3'b100: ctrl.aluOp = ALU_XOR;
            3'b101: ctrl.aluOp = ALU_SRL;
            3'b110: ctrl.aluOp = ALU_OR;
            default: ctrl.aluOp = ALU_AND;
          endcase
        end else if (funct7 == F7_ALT) begin
          if (funct3 == 3'b000) begin
            ctrl.aluOp = ALU_SUB; ctrl.illegal = 1'b0;
          end else if (funct3 == 3'b101) begin
            ctrl.aluOp = ALU_SRA; ctrl.illegal = 1'b0;
          end
        end
      end
      GRP_REG_W: begin
        ctrl.isWord = 1'b1;
        if (funct7 == F7_BASE) begin
          if (funct3 == 3'b000) begin
            ctrl.aluOp = ALU_ADD; ctrl.illegal = 1'b0;
          end else if (funct3 == 3'b001) begin
            ctrl.aluOp = ALU_SLL; ctrl.illegal = 1'b0;
          end else if (funct3 == 3'b101) begin
            ctrl.aluOp = ALU_SRL; ctrl.illegal = 1'b0;
          end
        end else if (funct7 == F7_ALT) begin
          if (funct3 == 3'b000) begin
            ctrl.aluOp = ALU_SUB; ctrl.illegal = 1'b0;
          end else if (funct3 == 3'b101) begin
            ctrl.aluOp = ALU_SRA; ctrl.illegal = 1'b0;
          end
        end
      end
      GRP_IMM: begin
        ctrl.useImm = 1'b1;
        unique case (funct3)
          3'b000: begin ctrl.aluOp = ALU_ADD;  ctrl.illegal = 1'b0; end
          3'b010: begin ctrl.aluOp = ALU_SLT;  ctrl.illegal = 1'b0; end
          3'b011: begin ctrl.aluOp = ALU_SLTU; ctrl.illegal = 1'b0; end
          3'b100: begin ctrl.aluOp = ALU_XOR;  ctrl.illegal = 1'b0; end
          3'b110: begin ctrl.aluOp = ALU_OR;   ctrl.illegal = 1'b0; end
          3'b111: begin ctrl.aluOp = ALU_AND;  ctrl.illegal = 1'b0; end
          3'b001: begin
            ctrl.aluOp = ALU_SLL;
            ctrl.illegal = (funct6 != F6_BASE);
          end
          default: begin
            if (funct6 == F6_BASE) begin
              ctrl.aluOp = ALU_SRL; ctrl.illegal = 1'b0;
            end else if (funct6 == F6_ALT) begin
              ctrl.aluOp = ALU_SRA; ctrl.illegal = 1'b0;
            end
          end
        endcase
      end
      GRP_IMM_W: begin
        ctrl.useImm = 1'b1;
        ctrl.isWord = 1'b1;
        if (funct3 == 3'b000) begin
          ctrl.aluOp = ALU_ADD; ctrl.illegal = 1'b0;
        end else if (funct3 == 3'b001) begin
          ctrl.aluOp = ALU_SLL;
          ctrl.illegal = (funct7 != F7_BASE);
        end else if (funct3 == 3'b101) begin
          if (funct7 == F7_BASE) begin
            ctrl.aluOp = ALU_SRL; ctrl.illegal = 1'b0;
          end else if (funct7 == F7_ALT) begin
            ctrl.aluOp = ALU_SRA; ctrl.illegal = 1'b0;
          end
        end
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

  assign wrEn = !ctrl.illegal && (rdField != '0);

endmodule

// File: rtl/rvx_exec_dp.sv
module rvx_exec_dp
  import rvx_exec_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 12
) (
  input  execCtrl_t        ctrl,
  input  logic [IMM_W-1:0] immField,
  input  logic [XLEN-1:0]  opA,
  input  logic [XLEN-1:0]  opReg,
  output logic [XLEN-1:0]  result
);

  localparam int WORD_W   = XLEN / 2;
  localparam int SHAMT_W  = $clog2(XLEN);
  localparam int WSHAMT_W = $clog2(WORD_W);

  logic [XLEN-1:0]    immExt, opB, raw, wordExt;
  logic [SHAMT_W-1:0] shamt;
  logic [WORD_W-1:0]  lowA, wordSrl, wordSra;
  logic               ltSigned, ltUnsigned;

  assign immExt = {{(XLEN-IMM_W){immField[IMM_W-1]}}, immField};
  assign opB    = ctrl.useImm ? immExt : opReg;
  assign lowA   = opA[WORD_W-1:0];

  // shift amount width is chosen by the word strobe
  assign shamt  = ctrl.isWord ? {1'b0, opB[WSHAMT_W-1:0]} : opB[SHAMT_W-1:0];

  assign ltSigned   = $signed(opA) < $signed(opB);
  assign ltUnsigned = opA < opB;

  assign wordSrl = lowA >> shamt[WSHAMT_W-1:0];
  assign wordSra = WORD_W'($signed(lowA) >>> shamt[WSHAMT_W-1:0]);

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_ADD:  raw = opA + opB;
      ALU_SUB:  raw = opA - opB;
      ALU_SLL:  raw = opA << shamt;
      ALU_SLT:  raw = {{(XLEN-1){1'b0}}, ltSigned};
      ALU_SLTU: raw = {{(XLEN-1){1'b0}}, ltUnsigned};
      ALU_XOR:  raw = opA ^ opB;
      ALU_SRL:  raw = ctrl.isWord ? {{WORD_W{1'b0}}, wordSrl} : (opA >> shamt);
      ALU_SRA:  raw = ctrl.isWord ? {{WORD_W{1'b0}}, wordSra}
                                  : XLEN'($signed(opA) >>> shamt);
      ALU_OR:   raw = opA | opB;
      default:  raw = opA & opB;
    endcase
  end

  assign wordExt = {{WORD_W{raw[WORD_W-1]}}, raw[WORD_W-1:0]};

  always_comb begin
    if (ctrl.illegal)     result = '0;
    else if (ctrl.isWord) result = wordExt;
    else                  result = raw;
  end

endmodule

// File: rtl/rvx_exec_unit.sv
module rvx_exec_unit
  import rvx_exec_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int ILEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic [ILEN-1:0]  instr,
  input  logic [XLEN-1:0]  rs1Val,
  input  logic [XLEN-1:0]  rs2Val,
  output logic [XLEN-1:0]  result,
  output logic [IDX_W-1:0] rdIdx,
  output logic             wrEn,
  output logic             illegal
);

  localparam int IMM_W = ILEN - 20;

  execCtrl_t ctrl;
  logic      unusedBits;

  assign unusedBits = ^{instr[1:0], instr[19:15]};
  assign rdIdx      = instr[11:7];
  assign illegal    = ctrl.illegal;

  rvx_exec_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .grp     (instr[6:2]),
    .funct3  (instr[14:12]),
    .funct7  (instr[31:25]),
    .rdField (instr[11:7]),
    .ctrl    (ctrl),
    .wrEn    (wrEn)
  );

  rvx_exec_dp #(.XLEN(XLEN), .IMM_W(IMM_W)) uDp (
    .ctrl     (ctrl),
    .immField (instr[ILEN-1:20]),
    .opA      (rs1Val),
    .opReg    (rs2Val),
    .result   (result)
  );

endmodule

// File: rtl/rvx_exec_chk.sv
module rvx_exec_chk #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input logic [31:0]      instr,
  input logic [XLEN-1:0]  result,
  input logic [IDX_W-1:0] rdIdx,
  input logic             wrEn,
  input logic             illegal
);

  logic isWordGrp, isCmp, unusedChk;
  assign unusedChk = ^{instr[31:15], instr[1:0]};
  assign isWordGrp = (instr[6:2] == 5'b01110) || (instr[6:2] == 5'b00110);
  assign isCmp     = (instr[6:2] == 5'b00100 || instr[6:2] == 5'b01100)
                     && (instr[14:13] == 2'b01);

  always_comb begin
    // R11
    illegal_blocks_write_chk: assert (!(illegal && wrEn));
    // R11
    illegal_zero_result_chk: assert (!illegal || result == '0);
    // R12
    x0_never_written_chk: assert (!(wrEn && rdIdx == '0));
    // R12
    rd_from_field_chk: assert (rdIdx == instr[11:7]);
    // R8
    word_sign_ext_chk: assert (!(isWordGrp && !illegal) ||
                               result[XLEN-1:31] == '0 || (&result[XLEN-1:31]));
    // R9
    cmp_is_bool_chk: assert (!(isCmp && !illegal) || result[XLEN-1:1] == '0);
    // R1
    unknown_group_chk: assert (!(instr[6:2] != 5'b01100 && instr[6:2] != 5'b01110 &&
                                 instr[6:2] != 5'b00100 && instr[6:2] != 5'b00110) || illegal);
  end

endmodule

bind rvx_exec_unit rvx_exec_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) uChk (
  .instr   (instr),
  .result  (result),
  .rdIdx   (rdIdx),
  .wrEn    (wrEn),
  .illegal (illegal)
);

// File: tb/tb_rvx_exec_unit.sv
module tb_rvx_exec_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] rs1Val = '0, rs2Val = '0;
  logic [63:0] result;
  logic [4:0]  rdIdx;
  logic        wrEn, illegal;
  int          nRun = 0, nFail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  rvx_exec_unit dut (
    .instr(instr), .rs1Val(rs1Val), .rs2Val(rs2Val),
    .result(result), .rdIdx(rdIdx), .wrEn(wrEn), .illegal(illegal)
  );

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // behavioural model: returns {illegal, writeEnable, value}
  function automatic logic [65:0] model(input logic [31:0] ins,
                                        input logic [63:0] a, input logic [63:0] r2);
    logic [4:0]  grp = ins[6:2];
    logic [2:0]  f3 = ins[14:12];
    logic [6:0]  f7 = ins[31:25];
    logic [63:0] imm = {{52{ins[31]}}, ins[31:20]};
    longint      sa = a;
    logic [63:0] v = 0;
    bit          bad = 0;
    int          s6, s5;
    logic [63:0] b;
    b  = (grp == 5'b00100 || grp == 5'b00110) ? imm : r2;
    s6 = int'(b[5:0]);
    s5 = int'(b[4:0]);
    case (grp)
      5'b01100: begin
        if (f7 == 7'h00)
          case (f3)
            0: v = a + b;              1: v = a << s6;
            2: v = (sa < longint'(b)) ? 1 : 0;
            3: v = (a < b) ? 1 : 0;    4: v = a ^ b;
            5: v = a >> s6;            6: v = a | b;
            default: v = a & b;
          endcase
        else if (f7 == 7'h20 && f3 == 0) v = a - b;
        else if (f7 == 7'h20 && f3 == 5) v = 64'(sa >>> s6);
        else bad = 1;
      end
      5'b01110: begin
        if      (f7 == 7'h00 && f3 == 0) v = sx32(32'(a + b));
        else if (f7 == 7'h20 && f3 == 0) v = sx32(32'(a - b));
        else if (f7 == 7'h00 && f3 == 1) v = sx32(32'(a[31:0] << s5));
        else if (f7 == 7'h00 && f3 == 5) v = sx32(a[31:0] >> s5);
        else if (f7 == 7'h20 && f3 == 5) v = sx32(32'(int'(a[31:0]) >>> s5));
        else bad = 1;
      end
      5'b00100: begin
        case (f3)
          0: v = a + b;
          2: v = (sa < longint'(b)) ? 1 : 0;
          3: v = (a < b) ? 1 : 0;
          4: v = a ^ b; 6: v = a | b; 7: v = a & b;
          1: if (ins[31:26] == 0) v = a << s6; else bad = 1;
          default: begin
            if (ins[31:26] == 6'h00) v = a >> s6;
            else if (ins[31:26] == 6'h10) v = 64'(sa >>> s6);
            else bad = 1;
          end
        endcase
      end
      5'b00110: begin
        if (f3 == 0) v = sx32(32'(a + b));
        else if (f3 == 1 && f7 == 7'h00) v = sx32(32'(a[31:0] << s5));
        else if (f3 == 5 && f7 == 7'h00) v = sx32(a[31:0] >> s5);
        else if (f3 == 5 && f7 == 7'h20) v = sx32(32'(int'(a[31:0]) >>> s5));
        else bad = 1;
      end
      default: bad = 1;
    endcase
    if (bad) v = 0;
    return {bad, !bad && ins[11:7] != 0, v};
  endfunction

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] r2,
                                      input logic [2:0] f3, input logic [4:0] rd,
                                      input logic [4:0] grp);
    return {f7, r2, 5'd1, f3, rd, grp, 2'b11};
  endfunction

  task automatic apply(input string tag, input logic [31:0] ins,
                       input logic [63:0] a, input logic [63:0] b);
    logic [65:0] e;
    @(negedge clk);
    instr = ins; rs1Val = a; rs2Val = b;
    #2;
    e = model(ins, a, b);
    nRun++;
    if (result !== e[63:0] || wrEn !== e[64] || illegal !== e[65] || rdIdx !== ins[11:7]) begin
      nFail++;
      $display("FAIL %s instr=%h got res=%h we=%b ill=%b rd=%0d exp res=%h we=%b ill=%b rd=%0d",
               tag, ins, result, wrEn, illegal, rdIdx, e[63:0], e[64], e[65], ins[11:7]);
    end
  endtask

  task automatic fixed(input string tag, input logic [31:0] ins,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] exp);
    apply(tag, ins, a, b);
    nRun++;
    if (result !== exp) begin
      nFail++;
      $display("FAIL %s fixed value got %h exp %h", tag, result, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: zero word is an unknown group
    nRun++;
    #2;
    if (illegal !== 1'b1 || wrEn !== 1'b0 || result !== '0) begin
      nFail++;
      $display("FAIL R1 reset-state ill=%b we=%b res=%h exp 1 0 0", illegal, wrEn, result);
    end
    rstN = 1'b1;

    // R10 wrap
    fixed("R10_add", enc(7'h00, 5'd2, 3'd0, 5'd3, 5'b01100), '1, 64'd1, 64'd0);
    fixed("R10_sub", enc(7'h20, 5'd2, 3'd0, 5'd3, 5'b01100), 64'd0, 64'd1, '1);
    // R2 ops
    fixed("R2_sra", enc(7'h20, 5'd2, 3'd5, 5'd4, 5'b01100), 64'h8000_0000_0000_0000, 64'd63, '1);
    fixed("R2_srl", enc(7'h00, 5'd2, 3'd5, 5'd4, 5'b01100), 64'h8000_0000_0000_0000, 64'd63, 64'd1);
    apply("R2_bad_f7", enc(7'h01, 5'd2, 3'd0, 5'd4, 5'b01100), 64'd5, 64'd6);
    // R7 shift amount masking
    fixed("R7_sll64", enc(7'h00, 5'd2, 3'd1, 5'd4, 5'b01100), 64'd1, 64'd65, 64'd2);
    fixed("R7_sllw", enc(7'h00, 5'd2, 3'd1, 5'd4, 5'b01110), 64'd1, 64'd33, 64'd2);
    // R8 word sign extension
    fixed("R8_addw", enc(7'h00, 5'd2, 3'd0, 5'd4, 5'b01110), 64'h7fff_ffff, 64'd1, 64'hffff_ffff_8000_0000);
    fixed("R8_sraw", enc(7'h20, 5'd2, 3'd5, 5'd4, 5'b01110), 64'h1_8000_0000, 64'd4, 64'hffff_ffff_f800_0000);
    fixed("R8_srlw", enc(7'h00, 5'd2, 3'd5, 5'd4, 5'b01110), 64'hffff_ffff_8000_0000, 64'd0, 64'hffff_ffff_8000_0000);
    // R3 unsupported word ops
    apply("R3_xorw", enc(7'h00, 5'd2, 3'd4, 5'd4, 5'b01110), 64'd1, 64'd2);
    apply("R3_sltw", enc(7'h00, 5'd2, 3'd2, 5'd4, 5'b01110), 64'd1, 64'd2);
    // R9 compare
    fixed("R9_slt", enc(7'h00, 5'd2, 3'd2, 5'd4, 5'b01100), '1, 64'd0, 64'd1);
    fixed("R9_sltu", enc(7'h00, 5'd2, 3'd3, 5'd4, 5'b01100), '1, 64'd0, 64'd0);
    fixed("R9_sltiu", {12'hfff, 5'd1, 3'd3, 5'd4, 5'b00100, 2'b11}, 64'd5, 64'd0, 64'd1);
    // R4 immediate sign extension
    fixed("R4_addi", {12'h800, 5'd1, 3'd0, 5'd4, 5'b00100, 2'b11}, 64'd0, 64'd0, 64'hffff_ffff_ffff_f800);
    fixed("R4_andi", {12'hff0, 5'd1, 3'd7, 5'd4, 5'b00100, 2'b11}, '1, 64'd0, 64'hffff_ffff_ffff_fff0);
    // R5 six-bit shift field
    fixed("R5_srai", {6'h10, 6'd60, 5'd1, 3'd5, 5'd4, 5'b00100, 2'b11}, 64'h8000_0000_0000_0000, 64'd0, 64'hffff_ffff_ffff_fff8);
    fixed("R5_slli63", {6'h00, 6'd63, 5'd1, 3'd1, 5'd4, 5'b00100, 2'b11}, 64'd1, 64'd0, 64'h8000_0000_0000_0000);
    apply("R5_bad", {6'h20, 6'd1, 5'd1, 3'd5, 5'd4, 5'b00100, 2'b11}, 64'd1, 64'd0);
    // R6 word immediate forms
    fixed("R6_sraiw", {7'h20, 5'd31, 5'd1, 3'd5, 5'd4, 5'b00110, 2'b11}, 64'h8000_0000, 64'd0, '1);
    apply("R6_slliw_b25", {7'h01, 5'd1, 5'd1, 3'd1, 5'd4, 5'b00110, 2'b11}, 64'd1, 64'd0);
    apply("R6_f3_2", {12'h001, 5'd1, 3'd2, 5'd4, 5'b00110, 2'b11}, 64'd1, 64'd0);
    // R12 rd zero, R11 illegal
    apply("R12_rd0", enc(7'h00, 5'd2, 3'd0, 5'd0, 5'b01100), 64'd1, 64'd1);
    apply("R11_illegal", enc(7'h00, 5'd2, 3'd0, 5'd9, 5'b11000), 64'd1, 64'd1);

    // biased random sweep covering R1..R12
    for (int i = 0; i < 4000; i++) begin
      logic [4:0]  g;
      logic [6:0]  f7;
      logic [31:0] ins;
      logic [63:0] a, b;
      case ($urandom_range(0, 4))
        0: g = 5'b01100; 1: g = 5'b01110; 2: g = 5'b00100; 3: g = 5'b00110;
        default: g = 5'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0: f7 = 7'h00; 1: f7 = 7'h20; 2: f7 = 7'h01; default: f7 = 7'($urandom);
      endcase
      ins = {f7, 25'($urandom)};
      ins[6:2] = g;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 7 == 0) a = {1'b1, 63'd0};
      if (i % 11 == 0) b = '1;
      apply("R1_R12_random", ins, a, b);
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    done = 1;
    $finish;
  end

endmodule